// File: doc/BRIEF.md
# Fail-Safe Down-Counting Pulse-Width Modulator

This block drives one pulse-width-modulated line. Two runtime values set its shape: a period length and a high-time, both in clock cycles. A down-counter counts through each period. The output is high only in the closing cycles of each period, while the counter is below the high-time value.

Because the high interval sits at the tail of the period, a bad setting fails safe. A high-time larger than the period, or a period of zero, cannot produce a line stuck high. The output stays low instead. A one-cycle marker flags the first cycle of every period, which lets other logic align to the waveform.

New settings arrive through a load strobe into holding registers. The counter uses them only when it next reloads, so a running period is never cut short or stretched. Control is a two-state machine:
- `ST_IDLE` is the state after reset and whenever enable is low. The line is low and the counter sits at its reload value.
- `ST_RUN` counts.
- Transition `GO` (enable high in `ST_IDLE`) moves to `ST_RUN`.
- Transition `HALT` (enable low in `ST_RUN`) moves back to `ST_IDLE`.
- Transition `WRAP` (counter at zero in `ST_RUN`) reloads and stays in `ST_RUN`.

Top module: `pwm_dncnt_gen`

## Requirements
- R1: While running, the counter steps down from P-1 to 0 and then reloads, so each period lasts P cycles. `period_start` is high in exactly the first cycle of each period. A period value of 0 acts as a one-cycle period.
- R2: With 0 < W <= P, `pwm_out` is low in the first P-W cycles of each period and high in its last W cycles.
- R3: When the active high-time W exceeds the active period P, `pwm_out` stays low for the whole run.
- R4: W = 0 gives a constant low output. W = P gives a constant high output, including P = W = 1.
- R5: A period of 0 is invalid. `pwm_out` stays low for any W, while `period_start` is high every cycle.
- R6: `cfg_period` and `cfg_width` are captured on a cycle with `cfg_load` high, and each is captured whole. The counter applies them only at its next reload, so the period in progress finishes with the previous values.
- R7: Enable low forces `pwm_out` and `period_start` low from the next cycle on. When enable rises again, a complete new period begins at its first cycle using the latest loaded values.
- R8: Reset drives both outputs low. It restores the settings to the defaults `DEF_PERIOD` and `DEF_WIDTH`, which then take effect when the block is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Run the generator when high |
| cfg_period | input | CNT_W | Period length in cycles |
| cfg_width | input | CNT_W | High-time in cycles |
| cfg_load | input | 1 | Capture `cfg_period` and `cfg_width` this cycle |
| pwm_out | output | 1 | Modulated output line |
| period_start | output | 1 | High in the first cycle of each period |

## Verification
The bench builds the block with an 8-bit counter and a default setting of period 5, high-time 2. These short periods make every position in a period visible in only a few cycles. The 8-bit range still leaves room for the period-of-zero case and for high-times larger than the period, both of which must give a low line.

The bench steps through a table of period and high-time pairs covering the following cases:
- zero high-time
- high-time equal to the period
- high-time larger than the period
- a one-cycle period
- a zero period

Directed sequences then load a new setting in the middle of a period, drop enable partway through a period, and check that reset restores the default setting.

// File: rtl/pwm_dn_pkg.sv
package pwm_dn_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } pwm_state_e;

    // Reload value of the down-counter for a given period (period 0 acts as 1).
    function automatic logic [31:0] reload_of(input logic [31:0] period);
        return (period == 32'd0) ? 32'd0 : period - 32'd1;
    endfunction

endpackage

// File: rtl/pwm_cfg_regs.sv
module pwm_cfg_regs #(
    parameter int CNT_W      = 8,
    parameter int DEF_PERIOD = 5,
    parameter int DEF_WIDTH  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_load,
    input  logic [CNT_W-1:0] cfg_period,
    input  logic [CNT_W-1:0] cfg_width,
    input  logic             commit,
    output logic [CNT_W-1:0] act_period,
    output logic [CNT_W-1:0] act_width,
    output logic [CNT_W-1:0] reload_val
);
    localparam logic [CNT_W-1:0] RST_PERIOD = CNT_W'(DEF_PERIOD);
    localparam logic [CNT_W-1:0] RST_WIDTH  = CNT_W'(DEF_WIDTH);

    logic [CNT_W-1:0] hold_period;
    logic [CNT_W-1:0] hold_width;

    // Holding registers: written by the load strobe at any time.
    always_ff @(posedge clk) begin
        if (rst) begin
            hold_period <= RST_PERIOD;
            hold_width  <= RST_WIDTH;
        end else if (cfg_load) begin
            hold_period <= cfg_period;
            hold_width  <= cfg_width;
        end
    end

    // Active registers: copied only at a counter reload.
    always_ff @(posedge clk) begin
        if (rst) begin
            act_period <= RST_PERIOD;
            act_width  <= RST_WIDTH;
        end else if (commit) begin
            act_period <= hold_period;
            act_width  <= hold_width;
        end
    end

    always_comb begin
        reload_val = CNT_W'(pwm_dn_pkg::reload_of(32'(hold_period)));
    end

    // R6
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !commit |=> ($stable(act_period) && $stable(act_width)));

endmodule

// File: rtl/pwm_down_counter.sv
module pwm_down_counter #(
    parameter int CNT_W      = 8,
    parameter int DEF_PERIOD = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             reload,
    input  logic [CNT_W-1:0] reload_val,
    output logic [CNT_W-1:0] cnt,
    output logic             at_zero
);
    localparam logic [CNT_W-1:0] RST_CNT =
        CNT_W'(pwm_dn_pkg::reload_of(32'(DEF_PERIOD)));
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= RST_CNT;
        end else if (reload) begin
            cnt <= reload_val;
        end else if (run) begin
            cnt <= cnt - ONE;
        end
    end

    always_comb begin
        at_zero = (cnt == '0);
    end

    // R1
    count_down_chk: assert property (@(posedge clk) disable iff (rst)
        (run && !reload) |=> (cnt == $past(cnt) - ONE));

endmodule

// File: rtl/pwm_level_cmp.sv
module pwm_level_cmp #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] act_period,
    input  logic [CNT_W-1:0] act_width,
    output logic             level
);
    logic cfg_valid;

    always_comb begin
        // Period 0 or a high-time beyond the period is invalid: hold low.
        cfg_valid = (act_period != '0) && (act_width <= act_period);
        level     = cfg_valid && (cnt < act_width);
    end

    // R3
    fail_low_chk: assert property (@(posedge clk) disable iff (rst)
        (act_width > act_period) |-> !level);

    // R5
    zero_period_chk: assert property (@(posedge clk) disable iff (rst)
        (act_period == '0) |-> !level);

endmodule

// File: rtl/pwm_dncnt_gen.sv
module pwm_dncnt_gen #(
    parameter int CNT_W      = 8,
    parameter int DEF_PERIOD = 5,
    parameter int DEF_WIDTH  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic [CNT_W-1:0] cfg_period,
    input  logic [CNT_W-1:0] cfg_width,
    input  logic             cfg_load,
    output logic             pwm_out,
    output logic             period_start
);
    import pwm_dn_pkg::*;

    pwm_state_e       state_q;
    pwm_state_e       state_d;
    logic             start_q;
    logic             reload;
    logic             run;
    logic             at_zero;
    logic             level;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] act_period;
    logic [CNT_W-1:0] act_width;
    logic [CNT_W-1:0] reload_val;

    // Next-state logic: GO, HALT, WRAP.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (enable)  state_d = ST_RUN;
            ST_RUN:  if (!enable) state_d = ST_IDLE;
            default:              state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        run    = (state_q == ST_RUN);
        reload = !run || at_zero;
    end

    // State register and period-start flag.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            start_q <= 1'b0;
        end else begin
            state_q <= state_d;
            start_q <= (state_d == ST_RUN) && reload;
        end
    end

    // Outputs.
    always_comb begin
        pwm_out      = run && level;
        period_start = start_q;
    end

    pwm_cfg_regs #(
        .CNT_W      (CNT_W),
        .DEF_PERIOD (DEF_PERIOD),
        .DEF_WIDTH  (DEF_WIDTH)
    ) i_cfg (
        .clk        (clk),
        .rst        (rst),
        .cfg_load   (cfg_load),
        .cfg_period (cfg_period),
        .cfg_width  (cfg_width),
        .commit     (reload),
        .act_period (act_period),
        .act_width  (act_width),
        .reload_val (reload_val)
    );

    pwm_down_counter #(
        .CNT_W      (CNT_W),
        .DEF_PERIOD (DEF_PERIOD)
    ) i_cnt (
        .clk        (clk),
        .rst        (rst),
        .run        (run),
        .reload     (reload),
        .reload_val (reload_val),
        .cnt        (cnt),
        .at_zero    (at_zero)
    );

    pwm_level_cmp #(
        .CNT_W      (CNT_W)
    ) i_cmp (
        .clk        (clk),
        .rst        (rst),
        .cnt        (cnt),
        .act_period (act_period),
        .act_width  (act_width),
        .level      (level)
    );

    // R7
    halt_low_chk: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (!pwm_out && !period_start));

    // R1
    wrap_start_chk: assert property (@(posedge clk) disable iff (rst)
        (run && at_zero && enable) |=> period_start);

    // R1
    start_single_chk: assert property (@(posedge clk) disable iff (rst)
        (period_start && act_period > 1) |=> !period_start);

endmodule

// File: tb/test_pwm_dncnt_gen.sv
module test_pwm_dncnt_gen;

    localparam int CNT_W = 8;
    localparam int DEF_P = 5;
    localparam int DEF_W = 2;
    localparam int NVEC  = 10;

    // {period, width}
    localparam logic [15:0] VECS [NVEC] = '{
        {8'd5, 8'd2}, {8'd5, 8'd0}, {8'd5, 8'd5}, {8'd5, 8'd7},
        {8'd1, 8'd1}, {8'd3, 8'd1}, {8'd8, 8'd3}, {8'd0, 8'd0},
        {8'd0, 8'd3}, {8'd4, 8'd9}
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             enable = 1'b0;
    logic [CNT_W-1:0] cfg_period = '0;
    logic [CNT_W-1:0] cfg_width = '0;
    logic             cfg_load = 1'b0;
    logic             pwm_out;
    logic             period_start;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pwm_dncnt_gen #(
        .CNT_W      (CNT_W),
        .DEF_PERIOD (DEF_P),
        .DEF_WIDTH  (DEF_W)
    ) i_pwm_dncnt_gen (
        .clk          (clk),
        .rst          (rst),
        .enable       (enable),
        .cfg_period   (cfg_period),
        .cfg_width    (cfg_width),
        .cfg_load     (cfg_load),
        .pwm_out      (pwm_out),
        .period_start (period_start)
    );

    // Expected {pwm_out, period_start} at position pos of a period.
    function automatic logic [1:0] expect_at(int p, int w, int pos);
        logic hi;
        hi = (p != 0) && (w <= p) && (pos >= p - w);
        return {hi, pos == 0};
    endfunction

    task automatic chk(string req, logic [1:0] exp_v);
        checks++;
        if ({pwm_out, period_start} !== exp_v) begin
            errors++;
            $display("FAIL %s: {pwm,start} actual=%b expected=%b at %0t",
                     req, {pwm_out, period_start}, exp_v, $time);
        end
    endtask

    task automatic run_cycles(int p, int w, int n, string req);
        int len;
        len = (p == 0) ? 1 : p;
        for (int i = 0; i < n; i++) begin
            chk(req, expect_at(p, w, i % len));
            @(negedge clk);
        end
    endtask

    // Load while idle, then enable; returns at position 0 of the first period.
    task automatic start_cfg(int p, int w);
        cfg_period = CNT_W'(p);
        cfg_width  = CNT_W'(w);
        cfg_load   = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
        enable   = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        // R8: reset state
        repeat (3) begin
            @(negedge clk);
            chk("R8", 2'b00);
        end
        rst = 1'b0;
        @(negedge clk);
        chk("R8", 2'b00);
        // R8: defaults used on first enable
        enable = 1'b1;
        @(negedge clk);
        run_cycles(DEF_P, DEF_W, 2 * DEF_P, "R8");
        enable = 1'b0;
        @(negedge clk);
        chk("R7", 2'b00);

        // Table walk: R1, R2, R3, R4, R5
        for (int v = 0; v < NVEC; v++) begin
            int p;
            int w;
            int len;
            p = int'(VECS[v][15:8]);
            w = int'(VECS[v][7:0]);
            len = (p == 0) ? 1 : p;
            start_cfg(p, w);
            if (p == 0)      run_cycles(p, w, 4, "R5");
            else if (w > p)  run_cycles(p, w, 2 * len, "R3");
            else if (w == 0 || w == p) run_cycles(p, w, 2 * len, "R4");
            else             run_cycles(p, w, 2 * len, "R2/R1");
            enable = 1'b0;
            @(negedge clk);
            chk("R7", 2'b00);
        end

        // R6: load mid-period, applied only at the next reload
        start_cfg(5, 2);
        chk("R6", expect_at(5, 2, 0));
        @(negedge clk);
        chk("R6", expect_at(5, 2, 1));
        cfg_period = 8'd4;
        cfg_width  = 8'd4;
        cfg_load   = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
        for (int pos = 2; pos < 5; pos++) begin
            chk("R6", expect_at(5, 2, pos));
            @(negedge clk);
        end
        run_cycles(4, 4, 8, "R6");
        // R6: change only the width, period unchanged
        cfg_width = 8'd1;
        cfg_load  = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
        for (int pos = 1; pos < 4; pos++) begin
            chk("R6", expect_at(4, 4, pos));
            @(negedge clk);
        end
        run_cycles(4, 1, 8, "R6");
        enable = 1'b0;
        @(negedge clk);

        // R7: halt mid-period, then restart at a fresh period
        start_cfg(6, 3);
        run_cycles(6, 3, 4, "R7");
        enable = 1'b0;
        repeat (3) begin
            @(negedge clk);
            chk("R7", 2'b00);
        end
        enable = 1'b1;
        @(negedge clk);
        run_cycles(6, 3, 12, "R7");

        // R8: reset restores the default setting
        rst    = 1'b1;
        enable = 1'b0;
        @(negedge clk);
        chk("R8", 2'b00);
        rst    = 1'b0;
        enable = 1'b1;
        @(negedge clk);
        run_cycles(DEF_P, DEF_W, 2 * DEF_P, "R8");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule